// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block moves an 18-bit word across two independent directions: A side to B side, and B side to A side. Each direction has a single storage stage that can act in one of four ways. It can pass data straight through, hold a latched word, capture on a rising edge of an external strobe, or capture on that edge only while a gate input allows it. Each direction presents its result as a data word plus a drive-enable flag. A pad ring or an upper-level tri-state model uses these to build the bus drivers.

The external strobes and the pass controls are plain inputs. The block samples them in the fast system clock domain. A rising strobe edge is found by comparing the present strobe level with the level seen on the previous system clock. In pass mode the output is combinational from the input. The storage also follows the input on every system clock, so when pass mode ends the storage holds the word present on the last system clock edge. The disconnect control touches only the drive-enable flag. Storage keeps working while a direction is disconnected.

Top module: `dual_path_xcvr`

## Requirements
- R1: The data path is DATA_W bits wide (default 18). Every bit position behaves identically and independently, so any bit pattern applied is reproduced exactly.
- R2: A direction's drive-enable output is 0 while its disconnect input (`*_hiz`) is 1, and 1 while that input is 0, with no clock delay.
- R3: While a direction's pass input is 1, its data output equals its data input in the same cycle.
- R4: While pass is 0 and the strobe holds steady at 0 or at 1, the data output keeps its previous value.
- R5: While pass is 0 and the gate input (`*_hold`) is 0, a system clock edge that sees the strobe at 1 after seeing it at 0 on the previous edge loads the data input. The new value appears on the data output after that edge.
- R6: While the gate input is 1, strobe rising edges are ignored and the stored word is kept.
- R7: A falling strobe edge never loads data.
- R8: Storage keeps loading and holding while the disconnect input is 1. A word loaded while disconnected appears as soon as the drive is enabled again.
- R9: While pass is 1, the storage takes the input on every system clock edge. After pass falls, the output holds the input sampled on the last edge that saw pass at 1.
- R10: The B-to-A direction mirrors A-to-B with its own disconnect, pass, strobe and gate inputs. The two directions run at the same time without affecting each other.
- R11: Reset clears both stored words to zero. A strobe already at 1 when reset is released is not taken as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | DATA_W | Word arriving on the A side |
| b_in | input | DATA_W | Word arriving on the B side |
| ab_hiz | input | 1 | A-to-B disconnect: 1 releases the B drivers |
| ab_pass | input | 1 | A-to-B pass-through select |
| ab_clk | input | 1 | A-to-B external capture strobe |
| ab_hold | input | 1 | A-to-B gate: 1 ignores strobe edges |
| ba_hiz | input | 1 | B-to-A disconnect: 1 releases the A drivers |
| ba_pass | input | 1 | B-to-A pass-through select |
| ba_clk | input | 1 | B-to-A external capture strobe |
| ba_hold | input | 1 | B-to-A gate: 1 ignores strobe edges |
| b_out | output | DATA_W | Word to drive onto the B side |
| b_drv | output | 1 | Drive enable for b_out |
| a_out | output | 1 x DATA_W | Word to drive onto the A side |
| a_drv | output | 1 | Drive enable for a_out |

## Verification
The bench ends pass mode at the same moment the input changes. A design that samples the word after pass falls, rather than on the last edge with pass high, would show the newer word. It lowers the strobe with fresh data present to catch storage that loads on either edge. It raises the strobe with the gate set to catch gating that does nothing. It holds the strobe at 1 through reset release, which exposes an edge detector that starts at the wrong level and loads a spurious word. It also runs both directions at once with different modes, where shared or crossed controls would corrupt the opposite output. It loads a word while disconnected, where a design that freezes storage along with the drivers would show the old word when drive returns.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;

   // Control bundle of one direction.
   typedef struct packed {
      logic hiz;      // 1: drivers released
      logic pass;     // 1: pass-through, storage tracks input
      logic ext_clk;  // external capture strobe
      logic hold;     // 1: strobe edges ignored
   } dir_ctrl_t;

   localparam logic STROBE_IDLE_LEVEL = 1'b1;

endpackage

// File: rtl/xcvr_edge_sense.sv
`timescale 1ns/1ps
module xcvr_edge_sense
   import xcvr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ext_clk,
   output logic rise
);

   logic prev_q;

   // Primed high: a strobe already high at reset release is no edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= STROBE_IDLE_LEVEL;
      else        prev_q <= ext_clk;
   end

   assign rise = ext_clk & ~prev_q;

   AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise) else $error("edge reported on two adjacent cycles"); // R5

endmodule

// File: rtl/xcvr_bit_cell.sv
`timescale 1ns/1ps
module xcvr_bit_cell #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   input  logic take,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RST_VAL;
      else if (take) q <= d;
   end

endmodule

// File: rtl/xcvr_lane.sv
`timescale 1ns/1ps
module xcvr_lane
   import xcvr_pkg::*;
#(
   parameter int unsigned DATA_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   input  dir_ctrl_t         ctrl,
   output logic [DATA_W-1:0] dout,
   output logic              drv
);

   localparam int unsigned MSB = DATA_W - 1;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("xcvr_lane: DATA_W must be at least 1");
      end
   endgenerate

   logic          rise;
   logic          take;
   logic [MSB:0]  store_q;

   xcvr_edge_sense u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .ext_clk (ctrl.ext_clk),
      .rise    (rise)
   );

   // Pass mode tracks every cycle; an edge in pass mode adds nothing.
   assign take = ctrl.pass | (rise & ~ctrl.hold);

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         xcvr_bit_cell #(.RST_VAL(1'b0)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (din[i]),
            .take  (take),
            .q     (store_q[i])
         );
      end
   endgenerate

   assign dout = ctrl.pass ? din : store_q;
   assign drv  = ~ctrl.hiz;

   AST_PASS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.pass |=> store_q == $past(din)) else $error("pass did not track"); // R9
   AST_STEADY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.pass && !rise) |=> $stable(store_q)) else $error("steady strobe changed store"); // R4
   AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.pass && ctrl.hold) |=> $stable(store_q)) else $error("gated edge loaded"); // R6
   AST_EDGE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.pass && !ctrl.hold && rise) |=> store_q == $past(din)) else $error("edge did not load"); // R5

endmodule

// File: rtl/dual_path_xcvr.sv
`timescale 1ns/1ps
module dual_path_xcvr
   import xcvr_pkg::*;
#(
   parameter int unsigned DATA_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   input  logic              ab_hiz,
   input  logic              ab_pass,
   input  logic              ab_clk,
   input  logic              ab_hold,
   input  logic              ba_hiz,
   input  logic              ba_pass,
   input  logic              ba_clk,
   input  logic              ba_hold,
   output logic [DATA_W-1:0] b_out,
   output logic              b_drv,
   output logic [DATA_W-1:0] a_out,
   output logic              a_drv
);

   dir_ctrl_t ab_ctrl, ba_ctrl;

   assign ab_ctrl = '{hiz: ab_hiz, pass: ab_pass, ext_clk: ab_clk, hold: ab_hold};
   assign ba_ctrl = '{hiz: ba_hiz, pass: ba_pass, ext_clk: ba_clk, hold: ba_hold};

   xcvr_lane #(.DATA_W(DATA_W)) u_ab (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (a_in),
      .ctrl  (ab_ctrl),
      .dout  (b_out),
      .drv   (b_drv)
   );

   xcvr_lane #(.DATA_W(DATA_W)) u_ba (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (b_in),
      .ctrl  (ba_ctrl),
      .dout  (a_out),
      .drv   (a_drv)
   );

   AST_AB_UNMOVED_BY_BA: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_pass && !ab_clk) |=> (ab_pass || $stable(b_out))) else $error("A-to-B disturbed"); // R10

endmodule

// File: tb/dual_path_xcvr_bench.sv
`timescale 1ns/1ps
module dual_path_xcvr_bench;

   localparam int W = 18;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [W-1:0] a_in, b_in, a_out, b_out;
   logic         ab_hiz, ab_pass, ab_clk, ab_hold;
   logic         ba_hiz, ba_pass, ba_clk, ba_hold;
   logic         a_drv, b_drv;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2 clk = ~clk;

   dual_path_xcvr #(.DATA_W(W)) u_dual_path_xcvr (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
      .ab_hiz(ab_hiz), .ab_pass(ab_pass), .ab_clk(ab_clk), .ab_hold(ab_hold),
      .ba_hiz(ba_hiz), .ba_pass(ba_pass), .ba_clk(ba_clk), .ba_hold(ba_hold),
      .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic t_reset();
      chk("R11 b_out after reset", b_out, '0);
      chk("R11 a_out after reset", a_out, '0);
      chk("R2 b_drv while disconnected", {17'b0, b_drv}, 18'd0);
   endtask

   task automatic t_transparent();
      ab_hiz = 0; ab_pass = 1; a_in = 18'h2A5C3;
      #1;
      chk("R3 pass output", b_out, 18'h2A5C3);
      chk("R2 b_drv enabled", {17'b0, b_drv}, 18'd1);
      a_in = 18'h15A3C;
      #1;
      chk("R1 pass complement pattern", b_out, 18'h15A3C);
   endtask

   task automatic t_latch_hold();
      ab_pass = 1; a_in = 18'h0F0F0;
      step();
      ab_pass = 0; a_in = 18'h3330C;
      step();
      chk("R9 held at pass fall", b_out, 18'h0F0F0);
      step(); step();
      chk("R4 steady strobe hold", b_out, 18'h0F0F0);
   endtask

   task automatic t_clock_load();
      ab_pass = 0; ab_hold = 0; ab_clk = 0;
      step();
      a_in = 18'h1E4B7; ab_clk = 1;
      step();
      chk("R5 rising strobe load", b_out, 18'h1E4B7);
      a_in = 18'h00FFF; ab_clk = 0;
      step();
      chk("R7 falling strobe ignored", b_out, 18'h1E4B7);
      step();
      chk("R4 strobe steady low", b_out, 18'h1E4B7);
   endtask

   task automatic t_clock_gate();
      ab_hold = 1; ab_clk = 0;
      step();
      a_in = 18'h2AAAA; ab_clk = 1;
      step();
      chk("R6 gated edge ignored", b_out, 18'h1E4B7);
      ab_clk = 0; ab_hold = 0;
      step();
      a_in = 18'h3FFFF; ab_clk = 1;
      step();
      chk("R1 all-ones load after ungate", b_out, 18'h3FFFF);
   endtask

   task automatic t_hiz();
      ab_hiz = 1; ab_clk = 0;
      step();
      a_in = 18'h24681; ab_clk = 1;
      step();
      chk("R2 b_drv off while disconnected", {17'b0, b_drv}, 18'd0);
      ab_hiz = 0;
      #1;
      chk("R8 word loaded while disconnected", b_out, 18'h24681);
   endtask

   task automatic t_mirror();
      ab_clk = 0; ba_hiz = 0; ba_pass = 1; b_in = 18'h13579;
      step();
      a_in = 18'h0ACE1; ab_clk = 1;
      step();
      chk("R10 ab loads alongside ba pass", b_out, 18'h0ACE1);
      chk("R10 ba pass concurrent", a_out, 18'h13579);
      chk("R10 a_drv enabled", {17'b0, a_drv}, 18'd1);
      ba_pass = 0; b_in = 18'h2BDF0; a_in = 18'h11111;
      step();
      chk("R10 ba held", a_out, 18'h13579);
      chk("R10 ab untouched", b_out, 18'h0ACE1);
      ba_clk = 1;
      step();
      chk("R10 ba strobe load", a_out, 18'h2BDF0);
      chk("R10 ab untouched by ba strobe", b_out, 18'h0ACE1);
   endtask

   task automatic t_reset_edge();
      ab_clk = 1; ab_pass = 0; ab_hold = 0; rst_n = 0;
      step(); step();
      chk("R11 reset clears store", b_out, '0);
      a_in = 18'h3C3C3; rst_n = 1;
      step(); step();
      chk("R11 high strobe at release not an edge", b_out, '0);
      ab_clk = 0;
      step();
      ab_clk = 1;
      step();
      chk("R11 first real edge loads", b_out, 18'h3C3C3);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 0; a_in = '0; b_in = '0;
      ab_hiz = 1; ab_pass = 0; ab_clk = 0; ab_hold = 0;
      ba_hiz = 1; ba_pass = 0; ba_clk = 0; ba_hold = 0;
      step(); step(); step();
      rst_n = 1;
      step();
      t_reset();
      t_transparent();
      t_latch_hold();
      t_clock_load();
      t_clock_gate();
      t_hiz();
      t_mirror();
      t_reset_edge();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule